// File: doc/BRIEF.md
# Scoreboard Wakeup Issue Queue

This block holds renamed instructions that wait for their source operands. Each slot keeps a thread number, a sequence number, two physical source tags with a ready flag for each, and a valid bit. A register-ready scoreboard has one bit per physical register. An instruction that arrives at the queue checks this scoreboard, so an operand that was produced while the instruction was on its way from rename is not waited on again.

A completion port sends out the destination tag of a finished instruction. Every waiting source that holds that tag becomes ready, and the scoreboard bit of that register is set. A completion and an insert in the same cycle meet through a bypass. A squash port removes every entry of one thread that is younger than a given sequence number. A dequeue port lets the selection logic outside the block free a slot by its index.

Readiness leaves the block as a per-slot bit vector. The block also reports the slot valid bits, the free-slot count and the occupancy of each thread. Selection policy, execution timing and memory ordering are handled elsewhere.

Top module: `wakeup_iq`

## Requirements
- R1: After reset no slot is valid, `free_slots` equals NUM_ENTRIES, every thread occupancy is zero and every scoreboard bit is clear. A tracked source inserted without its ready flag therefore waits.
- R2: An accepted insert with `ins_dst_en` set and a tracked destination tag clears that register's scoreboard bit. If a completion of the same tag arrives in the same cycle, the clear wins.
- R3: On insert, a source is stored as ready if its ready flag is set or its scoreboard bit is set. Otherwise it is stored as waiting.
- R4: A tag equal to or above NUM_PREGS is untracked. Such a source is stored as ready, and such a destination or completion tag leaves the scoreboard unchanged.
- R5: A completion with a tracked tag sets that scoreboard bit. It also marks ready, from the next cycle, every source of every valid slot that holds that tag.
- R6: An insert accepted in the same cycle as a completion whose tag equals one of its sources stores that source as ready.
- R7: `ready_vec[i]` is 1 exactly when slot i is valid and both of its sources are ready.
- R8: A squash of thread T with sequence S invalidates every valid slot of thread T whose sequence number is greater than S, compared unsigned. A slot with sequence equal to S, or a slot of another thread, stays. Each removed slot adds one to `free_slots` and subtracts one from T's occupancy.
- R9: An insert is ignored while `sq_valid` is high or when no slot is free.
- R10: A dequeue of a valid slot index invalidates that slot, adds one free slot and lowers the occupancy of the slot's thread. A dequeue of an invalid slot does nothing.
- R11: An accepted insert goes into the lowest-numbered slot that was free before the edge, and it raises its thread's occupancy by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_thread | input | THR_W (1) | Thread of the inserted instruction |
| ins_seq | input | SEQ_W (8) | Sequence number of the inserted instruction |
| ins_src0_tag | input | TAG_W (6) | First source physical tag |
| ins_src0_rdy | input | 1 | First source already known ready |
| ins_src1_tag | input | TAG_W (6) | Second source physical tag |
| ins_src1_rdy | input | 1 | Second source already known ready |
| ins_dst_en | input | 1 | Instruction writes a destination |
| ins_dst_tag | input | TAG_W (6) | Destination physical tag |
| wk_valid | input | 1 | Completion broadcast valid |
| wk_tag | input | TAG_W (6) | Destination tag of the completed instruction |
| sq_valid | input | 1 | Squash request |
| sq_thread | input | THR_W (1) | Thread to squash |
| sq_seq | input | SEQ_W (8) | Entries younger than this are removed |
| deq_valid | input | 1 | Dequeue request |
| deq_idx | input | IDX_W (3) | Slot index to dequeue |
| ready_vec | output | NUM_ENTRIES (8) | Per-slot ready-to-issue bits |
| valid_vec | output | NUM_ENTRIES (8) | Per-slot valid bits |
| free_slots | output | CNT_W (4) | Number of free slots |
| thread_occ | output | NUM_THREADS*CNT_W (8) | Per-thread occupancy, thread t at bits t*CNT_W upward |

## Verification
Some rules are checked by assertions on every cycle. The free-slot counter must agree with the population of the slot valid bits, and the thread occupancies must sum to the used slots. The allocator may grant at most one slot and none when full. A squash hit must empty its slot while other threads' slots survive, and a matching completion must set the scoreboard bit and the waiting source flag. The bench's scenarios are needed for the rest: the stored scoreboard effect, since a cleared destination shows only through a later insert that waits; the bypass between completion and insert; the boundary case of a sequence equal to the squash point; the ignored inserts; and lowest-slot reuse after a dequeue. A behavioural model runs under long random traffic and is compared with the outputs every cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int DEF_ENTRIES = 8;
  localparam int DEF_PREGS   = 32;
  localparam int DEF_TAG_W   = 6;
  localparam int DEF_SEQ_W   = 8;
  localparam int DEF_THREADS = 2;

  // A tag is tracked by the scoreboard only when it names a real register.
  function automatic logic tag_tracked(input logic [31:0] tag, input int nregs);
    return tag < 32'(nregs);
  endfunction
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int NUM_PREGS = 32,
  parameter int TAG_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [TAG_W-1:0] lk0_tag,
  input  logic [TAG_W-1:0] lk1_tag,
  output logic             lk0_hit,
  output logic             lk1_hit
);
  import iq_pkg::*;
  localparam int PIDX_W = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1;

  logic [NUM_PREGS-1:0] sb_q, sb_d;
  logic [PIDX_W-1:0]    wk_idx, clr_idx, lk0_idx, lk1_idx;
  logic                 wk_trk, clr_trk, lk0_trk, lk1_trk;

  assign wk_idx  = wk_tag[PIDX_W-1:0];
  assign clr_idx = clr_tag[PIDX_W-1:0];
  assign lk0_idx = lk0_tag[PIDX_W-1:0];
  assign lk1_idx = lk1_tag[PIDX_W-1:0];
  assign wk_trk  = tag_tracked(32'(wk_tag), NUM_PREGS);
  assign clr_trk = tag_tracked(32'(clr_tag), NUM_PREGS);
  assign lk0_trk = tag_tracked(32'(lk0_tag), NUM_PREGS);
  assign lk1_trk = tag_tracked(32'(lk1_tag), NUM_PREGS);

  // Lookup with same-cycle completion bypass; untracked tags count as ready.
  always_comb begin
    lk0_hit = !lk0_trk || sb_q[lk0_idx] || (wk_valid && wk_tag == lk0_tag);
    lk1_hit = !lk1_trk || sb_q[lk1_idx] || (wk_valid && wk_tag == lk1_tag);
  end

  always_comb begin
    sb_d = sb_q;
    if (wk_valid && wk_trk) sb_d[wk_idx] = 1'b1;
    if (clr_en && clr_trk)  sb_d[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sb_q <= '0;
    else if ((wk_valid && wk_trk) || (clr_en && clr_trk)) sb_q <= sb_d;
  end

  assert_wake_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_valid && wk_trk && !(clr_en && clr_tag == wk_tag)) |=> sb_q[$past(wk_idx)]);

  assert_dst_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_trk) |=> !sb_q[$past(clr_idx)]);
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int NUM_ENTRIES = 8
) (
  input  logic [NUM_ENTRIES-1:0] busy,
  output logic [NUM_ENTRIES-1:0] grant,
  output logic                   any_free
);
  // Lowest free slot wins: scan from the top so the last hit is the lowest.
  always_comb begin
    grant = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
    any_free = !(&busy);
  end
endmodule

// File: rtl/iq_entry.sv
module iq_entry #(
  parameter int TAG_W = 6,
  parameter int SEQ_W = 8,
  parameter int THR_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [THR_W-1:0] a_thread,
  input  logic [SEQ_W-1:0] a_seq,
  input  logic [TAG_W-1:0] a_s0_tag,
  input  logic             a_s0_rdy,
  input  logic [TAG_W-1:0] a_s1_tag,
  input  logic             a_s1_rdy,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             sq_valid,
  input  logic [THR_W-1:0] sq_thread,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             deq,
  output logic             e_valid,
  output logic             e_ready,
  output logic             e_drop,
  output logic [THR_W-1:0] e_thread
);
  logic             v_q, v_d;
  logic             r0_q, r0_d, r1_q, r1_d;
  logic [THR_W-1:0] thr_q;
  logic [SEQ_W-1:0] seq_q;
  logic [TAG_W-1:0] t0_q, t1_q;
  logic             sq_hit, wake0, wake1, rdy_en;

  assign sq_hit = v_q && sq_valid && (thr_q == sq_thread) && (seq_q > sq_seq);
  assign e_drop = v_q && (deq || sq_hit);
  assign wake0  = wk_valid && (wk_tag == t0_q);
  assign wake1  = wk_valid && (wk_tag == t1_q);

  always_comb begin
    v_d  = v_q;
    r0_d = r0_q | wake0;
    r1_d = r1_q | wake1;
    if (e_drop) v_d = 1'b0;
    if (alloc) begin
      v_d  = 1'b1;
      r0_d = a_s0_rdy;
      r1_d = a_s1_rdy;
    end
  end
  assign rdy_en = alloc || (v_q && (wake0 || wake1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      r0_q <= 1'b0;
      r1_q <= 1'b0;
    end else begin
      if (alloc || e_drop) v_q <= v_d;
      if (rdy_en) begin
        r0_q <= r0_d;
        r1_q <= r1_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      thr_q <= a_thread;
      seq_q <= a_seq;
      t0_q  <= a_s0_tag;
      t1_q  <= a_s1_tag;
    end
  end

  assign e_valid  = v_q;
  assign e_ready  = v_q && r0_q && r1_q;
  assign e_thread = thr_q;

  assert_squash_kills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_hit |=> !v_q);

  assert_other_thread_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && sq_valid && thr_q != sq_thread && !deq) |=> v_q);

  assert_wake_src0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !r0_q && wake0 && !e_drop) |=> r0_q);
endmodule

// File: rtl/wakeup_iq.sv
module wakeup_iq #(
  parameter int NUM_ENTRIES = iq_pkg::DEF_ENTRIES,
  parameter int NUM_PREGS   = iq_pkg::DEF_PREGS,
  parameter int TAG_W       = iq_pkg::DEF_TAG_W,
  parameter int SEQ_W       = iq_pkg::DEF_SEQ_W,
  parameter int NUM_THREADS = iq_pkg::DEF_THREADS,
  localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ins_valid,
  input  logic [THR_W-1:0]             ins_thread,
  input  logic [SEQ_W-1:0]             ins_seq,
  input  logic [TAG_W-1:0]             ins_src0_tag,
  input  logic                         ins_src0_rdy,
  input  logic [TAG_W-1:0]             ins_src1_tag,
  input  logic                         ins_src1_rdy,
  input  logic                         ins_dst_en,
  input  logic [TAG_W-1:0]             ins_dst_tag,
  input  logic                         wk_valid,
  input  logic [TAG_W-1:0]             wk_tag,
  input  logic                         sq_valid,
  input  logic [THR_W-1:0]             sq_thread,
  input  logic [SEQ_W-1:0]             sq_seq,
  input  logic                         deq_valid,
  input  logic [IDX_W-1:0]             deq_idx,
  output logic [NUM_ENTRIES-1:0]       ready_vec,
  output logic [NUM_ENTRIES-1:0]       valid_vec,
  output logic [CNT_W-1:0]             free_slots,
  output logic [NUM_THREADS*CNT_W-1:0] thread_occ
);
  logic [NUM_ENTRIES-1:0] grant, alloc_vec, drop_vec;
  logic                   any_free, ins_take;
  logic                   s0_hit, s1_hit;
  logic [THR_W-1:0]       ent_thr [NUM_ENTRIES];
  logic [CNT_W-1:0]       free_q, free_d;
  logic [CNT_W-1:0]       occ_q [NUM_THREADS];
  logic [CNT_W-1:0]       occ_d [NUM_THREADS];
  logic                   cnt_en;
  int                     occ_sum;

  assign ins_take  = ins_valid && !sq_valid && any_free;
  assign alloc_vec = grant & {NUM_ENTRIES{ins_take}};

  iq_alloc #(.NUM_ENTRIES(NUM_ENTRIES)) u_alloc (
    .busy(valid_vec), .grant(grant), .any_free(any_free)
  );

  iq_scoreboard #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .wk_valid(wk_valid), .wk_tag(wk_tag),
    .clr_en(ins_take && ins_dst_en), .clr_tag(ins_dst_tag),
    .lk0_tag(ins_src0_tag), .lk1_tag(ins_src1_tag),
    .lk0_hit(s0_hit), .lk1_hit(s1_hit)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    iq_entry #(.TAG_W(TAG_W), .SEQ_W(SEQ_W), .THR_W(THR_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_vec[g]),
      .a_thread(ins_thread), .a_seq(ins_seq),
      .a_s0_tag(ins_src0_tag), .a_s0_rdy(ins_src0_rdy || s0_hit),
      .a_s1_tag(ins_src1_tag), .a_s1_rdy(ins_src1_rdy || s1_hit),
      .wk_valid(wk_valid), .wk_tag(wk_tag),
      .sq_valid(sq_valid), .sq_thread(sq_thread), .sq_seq(sq_seq),
      .deq(deq_valid && (deq_idx == IDX_W'(g))),
      .e_valid(valid_vec[g]), .e_ready(ready_vec[g]),
      .e_drop(drop_vec[g]), .e_thread(ent_thr[g])
    );
  end

  // Slot and per-thread accounting.
  always_comb begin
    free_d = free_q - CNT_W'(ins_take);
    for (int i = 0; i < NUM_ENTRIES; i++) free_d = free_d + CNT_W'(drop_vec[i]);
    for (int t = 0; t < NUM_THREADS; t++) begin
      occ_d[t] = occ_q[t] + CNT_W'(ins_take && ins_thread == THR_W'(t));
      for (int i = 0; i < NUM_ENTRIES; i++)
        occ_d[t] = occ_d[t] - CNT_W'(drop_vec[i] && ent_thr[i] == THR_W'(t));
    end
  end
  assign cnt_en = ins_take || (|drop_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= CNT_W'(NUM_ENTRIES);
      for (int t = 0; t < NUM_THREADS; t++) occ_q[t] <= '0;
    end else if (cnt_en) begin
      free_q <= free_d;
      for (int t = 0; t < NUM_THREADS; t++) occ_q[t] <= occ_d[t];
    end
  end

  assign free_slots = free_q;
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_occ
    assign thread_occ[t*CNT_W +: CNT_W] = occ_q[t];
  end

  always_comb begin
    occ_sum = 0;
    for (int t = 0; t < NUM_THREADS; t++) occ_sum = occ_sum + int'(occ_q[t]);
  end

  assert_free_matches_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_q) == NUM_ENTRIES - $countones(valid_vec));

  assert_occ_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum + int'(free_q) == NUM_ENTRIES);

  assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  assert_full_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == '0) |-> (alloc_vec == '0));
endmodule

// File: tb/wakeup_iq_tb.sv
module wakeup_iq_tb;
  localparam int NE = 8;
  localparam int NP = 32;
  localparam int CW = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ins_valid, ins_src0_rdy, ins_src1_rdy, ins_dst_en;
  logic [0:0] ins_thread, sq_thread;
  logic [7:0] ins_seq, sq_seq;
  logic [5:0] ins_src0_tag, ins_src1_tag, ins_dst_tag, wk_tag;
  logic       wk_valid, sq_valid, deq_valid;
  logic [2:0] deq_idx;
  logic [NE-1:0] ready_vec, valid_vec;
  logic [CW-1:0] free_slots;
  logic [2*CW-1:0] thread_occ;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state
  bit m_v [NE];
  bit m_r0 [NE];
  bit m_r1 [NE];
  int m_thr [NE];
  int m_seq [NE];
  int m_t0 [NE];
  int m_t1 [NE];
  bit m_sb [NP];

  wakeup_iq u_dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_thread(ins_thread), .ins_seq(ins_seq),
    .ins_src0_tag(ins_src0_tag), .ins_src0_rdy(ins_src0_rdy),
    .ins_src1_tag(ins_src1_tag), .ins_src1_rdy(ins_src1_rdy),
    .ins_dst_en(ins_dst_en), .ins_dst_tag(ins_dst_tag),
    .wk_valid(wk_valid), .wk_tag(wk_tag),
    .sq_valid(sq_valid), .sq_thread(sq_thread), .sq_seq(sq_seq),
    .deq_valid(deq_valid), .deq_idx(deq_idx),
    .ready_vec(ready_vec), .valid_vec(valid_vec),
    .free_slots(free_slots), .thread_occ(thread_occ)
  );

  always #10 clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_thread = 0; ins_seq = 0;
    ins_src0_tag = 0; ins_src0_rdy = 0; ins_src1_tag = 0; ins_src1_rdy = 0;
    ins_dst_en = 0; ins_dst_tag = 0;
    wk_valid = 0; wk_tag = 0;
    sq_valid = 0; sq_thread = 0; sq_seq = 0;
    deq_valid = 0; deq_idx = 0;
  endtask

  task automatic ins(input int thr, input int seq, input int t0, input bit r0,
                     input int t1, input bit r1, input bit den, input int dst);
    ins_valid = 1; ins_thread = 1'(thr); ins_seq = 8'(seq);
    ins_src0_tag = 6'(t0); ins_src0_rdy = r0;
    ins_src1_tag = 6'(t1); ins_src1_rdy = r1;
    ins_dst_en = den; ins_dst_tag = 6'(dst);
  endtask

  function automatic bit src_ok(input int tag, input bit flag);
    if (flag || tag >= NP) return 1;
    if (m_sb[tag]) return 1;
    return wk_valid && int'(wk_tag) == tag;
  endfunction

  task automatic model_step();
    int  nfree;
    int  idx;
    bit  take;
    bit  a0;
    bit  a1;
    nfree = 0; idx = -1;
    for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) begin nfree++; idx = i; end
    take = ins_valid && !sq_valid && nfree > 0;
    a0 = src_ok(int'(ins_src0_tag), ins_src0_rdy);
    a1 = src_ok(int'(ins_src1_tag), ins_src1_rdy);
    for (int i = 0; i < NE; i++) begin
      if (m_v[i]) begin
        if (sq_valid && m_thr[i] == int'(sq_thread) && m_seq[i] > int'(sq_seq)) m_v[i] = 0;
        if (deq_valid && int'(deq_idx) == i) m_v[i] = 0;
        if (wk_valid && int'(wk_tag) == m_t0[i]) m_r0[i] = 1;
        if (wk_valid && int'(wk_tag) == m_t1[i]) m_r1[i] = 1;
      end
    end
    if (wk_valid && int'(wk_tag) < NP) m_sb[int'(wk_tag)] = 1;
    if (take && ins_dst_en && int'(ins_dst_tag) < NP) m_sb[int'(ins_dst_tag)] = 0;
    if (take) begin
      m_v[idx] = 1; m_thr[idx] = int'(ins_thread); m_seq[idx] = int'(ins_seq);
      m_t0[idx] = int'(ins_src0_tag); m_t1[idx] = int'(ins_src1_tag);
      m_r0[idx] = a0; m_r1[idx] = a1;
    end
  endtask

  task automatic compare();
    logic [NE-1:0] ev;
    logic [NE-1:0] er;
    int o0;
    int o1;
    ev = '0; er = '0; o0 = 0; o1 = 0;
    for (int i = 0; i < NE; i++) begin
      ev[i] = m_v[i];
      er[i] = m_v[i] && m_r0[i] && m_r1[i];
      if (m_v[i] && m_thr[i] == 0) o0++;
      if (m_v[i] && m_thr[i] == 1) o1++;
    end
    chk(int'(ready_vec), int'(er), "R7 ready vector vs model");
    chk(int'(valid_vec), int'(ev), "R11 valid vector vs model");
    chk(int'(free_slots), NE - o0 - o1, "R10 free slots vs model");
    chk(int'(thread_occ[CW-1:0]), o0, "R8 thread0 occupancy vs model");
    chk(int'(thread_occ[2*CW-1:CW]), o1, "R8 thread1 occupancy vs model");
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_r0[i] = 0; m_r1[i] = 0; end
    for (int i = 0; i < NP; i++) m_sb[i] = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(int'(valid_vec), 0, "R1 no valid slot");
    chk(int'(free_slots), NE, "R1 all slots free");
    chk(int'(thread_occ), 0, "R1 occupancy zero");

    ins(0, 10, 3, 0, 4, 0, 1, 5); step();
    chk(int'(ready_vec[0]), 0, "R1 R3 source waits after reset");
    ins(0, 11, 5, 0, 40, 0, 1, 6); step();
    chk(int'(ready_vec[1]), 0, "R3 tracked source waits");
    wk_valid = 1; wk_tag = 3; step();
    chk(int'(ready_vec[0]), 0, "R5 one of two sources woken");
    wk_valid = 1; wk_tag = 4; step();
    chk(int'(ready_vec[0]), 1, "R5 both sources woken");
    wk_valid = 1; wk_tag = 5; step();
    chk(int'(ready_vec[1]), 1, "R4 untracked source ready, R5 wake");
    wk_valid = 1; wk_tag = 40; step();
    ins(1, 20, 5, 0, 5, 0, 0, 0); step();
    chk(int'(ready_vec[2]), 1, "R3 scoreboard hit on insert");
    ins(1, 21, 9, 0, 9, 1, 1, 5); step();
    ins(1, 22, 5, 0, 5, 0, 0, 0); step();
    chk(int'(ready_vec[4]), 0, "R2 destination cleared scoreboard");
    ins(0, 12, 9, 0, 7, 1, 0, 0); wk_valid = 1; wk_tag = 9; step();
    chk(int'(ready_vec[5]), 1, "R6 bypass of same-cycle completion");
    chk(int'(ready_vec[3]), 1, "R5 waiting slot woken");
    ins(0, 13, 12, 1, 13, 1, 0, 0); step();
    chk(int'(ready_vec[6]), 1, "R3 flagged sources ready");
    ins(0, 14, 20, 0, 21, 0, 0, 0); step();
    chk(int'(free_slots), 0, "R11 queue full");
    ins(1, 30, 1, 1, 1, 1, 0, 0); step();
    chk(int'(thread_occ[2*CW-1:CW]), 3, "R9 insert when full ignored");
    sq_valid = 1; sq_thread = 0; sq_seq = 11; step();
    chk(int'(valid_vec), 8'h1F, "R8 younger thread0 slots removed");
    chk(int'(free_slots), 3, "R8 free slots returned");
    chk(int'(thread_occ[CW-1:0]), 2, "R8 thread0 occupancy lowered");
    sq_valid = 1; sq_thread = 1; sq_seq = 21; ins(1, 50, 1, 1, 1, 1, 0, 0); step();
    chk(int'(valid_vec), 8'h0F, "R9 insert during squash ignored, R8");
    chk(int'(thread_occ[2*CW-1:CW]), 2, "R8 thread1 occupancy");
    sq_valid = 1; sq_thread = 0; sq_seq = 11; step();
    chk(int'(valid_vec[1]), 1, "R8 equal sequence kept");
    deq_valid = 1; deq_idx = 0; step();
    chk(int'(valid_vec[0]), 0, "R10 dequeue frees slot");
    chk(int'(thread_occ[CW-1:0]), 1, "R10 occupancy lowered");
    deq_valid = 1; deq_idx = 6; step();
    chk(int'(free_slots), 5, "R10 dequeue of empty slot no effect");
    ins(1, 60, 1, 1, 1, 1, 0, 0); step();
    chk(int'(valid_vec[0]), 1, "R11 lowest free slot reused");
    chk(int'(thread_occ[2*CW-1:CW]), 3, "R11 occupancy raised");

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) != 0)
        ins(int'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 39)), 1'($urandom_range(0, 3) == 0),
            int'($urandom_range(0, 39)), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 39)));
      if ($urandom_range(0, 1) == 1) begin
        wk_valid = 1; wk_tag = 6'($urandom_range(0, 39));
      end
      if ($urandom_range(0, 11) == 0) begin
        sq_valid = 1; sq_thread = 1'($urandom_range(0, 1));
        sq_seq = 8'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 3) == 0) begin
        deq_valid = 1; deq_idx = 3'($urandom_range(0, 7));
      end
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule